// File: doc/BRIEF.md
# Single-Address DMA Engine with Boundary Pause

This block moves data for an SD host controller between the card data path and system memory without descriptor processing. Software programs a system address, a block length, a boundary code, a block count and a set of transfer mode bits, then pulses a start strobe. The engine then streams whole 32-bit words. In one direction it packs bytes from the card stream into words and writes them to memory. In the other it fetches words from memory and unpacks them into a byte stream toward the card.

Software can pick an address boundary, a power of two from 4 KiB to 512 KiB. Each time the running address reaches that boundary, the engine halts and raises a pause status flag. Software restarts the transfer by writing the system address register. It may write back the address it reads, which is the next address to be accessed, or any other address to relocate the rest of the transfer. When the final word of the final block has moved, the engine sets a completion flag and returns to idle. Both flags are write-one-to-clear, and each is gated by its own enable.

Top module: `sdma_engine`

## Requirements
- R1: After reset the engine is idle, `sysAddrOut`, `blkCntOut` and both status flags are 0, and no memory request or stream handshake signal is active.
- R2: A start strobe is accepted only when all of these hold: the engine is idle, `dmaSel` is 2'b00, `xferMode[0]` (DMA enable) is 1, `blkSizeReg[11:2]` is nonzero, and, if `xferMode[5]` (multi-block) is 1, `blkCntIn` is nonzero. The codes 2'b01, 2'b10 and 2'b11 leave the engine idle.
- R3: With `xferMode[4]` = 1, bytes accepted on the card input stream are packed into words, with the first byte in bits [7:0], and written to memory. With `xferMode[4]` = 0, words read from memory are sent on the card output stream starting with bits [7:0].
- R4: Each accepted memory access advances the address by 4. The address is always word aligned, and `sysAddrOut` shows the next address to be accessed.
- R5: The block length in bytes is `blkSizeReg[11:0]`, used in whole words. With `xferMode[5]` = 1 the engine moves `blkCntIn` blocks. With `xferMode[5]` = 0 it moves exactly one block, whatever the count.
- R6: `blkCntOut` loads `blkCntIn` at start. With `xferMode[1]` = 1 it decrements after each completed block and never goes below 0. With `xferMode[1]` = 0 it stays unchanged.
- R7: The boundary size is 4096 << `blkSizeReg[14:12]` bytes. When a word completes that is not the last word of the transfer, and the next address is a multiple of the boundary size, the engine pauses. If the last word lands on a boundary, the transfer completes instead of pausing.
- R8: A write to the system address while paused loads the written address with bits [1:0] cleared, and resumes the transfer. A write while idle only loads the address. A write while running is ignored.
- R9: After the last word of the last block, the engine returns to idle.
- R10: Status bit 0 (completion) is set on completion and status bit 1 (pause) is set on a boundary pause, each only when the matching `stsEn` bit is 1.
- R11: Writing 1 to a `stsClr` bit clears that status flag, and writing 0 leaves it unchanged. A set in the same cycle takes priority over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dmaSel | input | 2 | DMA type select; only 2'b00 operates |
| xferMode | input | 6 | Transfer mode: [0] DMA enable, [1] count enable, [4] direction, [5] multi-block |
| blkSizeReg | input | 16 | [11:0] block length in bytes, [14:12] boundary code |
| blkCntIn | input | 16 | Programmed block count |
| startStb | input | 1 | Start request pulse |
| sysAddrWrEn | input | 1 | System address write strobe |
| sysAddrWrData | input | 32 | System address write value |
| stsEn | input | 2 | Status set enables: [0] completion, [1] pause |
| stsClr | input | 2 | Write-one-to-clear strobes for the status bits |
| sysAddrOut | output | 32 | Next address to be accessed |
| blkCntOut | output | 16 | Current block count |
| busy | output | 1 | Running or paused |
| stsXferDone | output | 1 | Completion status flag |
| stsDmaInt | output | 1 | Boundary pause status flag |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Memory write (1) or read (0) |
| memAddr | output | 32 | Memory word address |
| memWdata | output | 32 | Memory write data |
| memRdy | input | 1 | Memory accepts the request this cycle |
| memRdata | input | 32 | Memory read data, valid with memRdy |
| cardInValid | input | 1 | Card-to-engine byte valid |
| cardInData | input | 8 | Card-to-engine byte |
| cardInReady | output | 1 | Engine accepts a card byte |
| cardOutValid | output | 1 | Engine-to-card byte valid |
| cardOutData | output | 8 | Engine-to-card byte |
| cardOutReady | input | 1 | Card accepts the byte |

## Verification
The hardest state to reach is a pause that falls exactly at a block edge in a multi-block transfer. In that state the word counter has just reloaded while the block counter still has work left, and the engine must wait for an address write instead of fetching. The stimulus reaches it by starting a few words below a 4 KiB or 8 KiB boundary, so a boundary comes up after a handful of words rather than after a thousand. Memory and stream readiness stall at random on every cycle. The resume then writes either the read-back address or a relocated one. Other runs cover the case where the last word lands on a boundary, and a code-1 run that passes a 4 KiB multiple without pausing.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_PAUSE = 2'd2
  } sdmaState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;     // start accepted: reset packing state, latch direction
    logic run;       // handshakes allowed
    logic loadAddr;  // system address write accepted
    logic dirIn;     // 1: card to memory
  } dpCmd_t;

  localparam int STS_DONE = 0;
  localparam int STS_DMA  = 1;

endpackage

// File: rtl/sdma_dpath.sv
module sdma_dpath
  import sdma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [ADDR_W-1:0] addrWrData,
  output logic [ADDR_W-1:0] addrQ,
  output logic              wordDone,
  output logic [ADDR_W-1:0] postAddr,
  output logic              memReq,
  output logic              memWe,
  output logic [31:0]       memWdata,
  input  logic              memRdy,
  input  logic [31:0]       memRdata,
  input  logic              cardInValid,
  input  logic [7:0]        cardInData,
  output logic              cardInReady,
  output logic              cardOutValid,
  output logic [7:0]        cardOutData,
  input  logic              cardOutReady
);

  logic        dirQ;
  logic [31:0] packQ;
  logic [1:0]  byteIdx;
  logic        fullQ;
  logic        haveQ;
  logic        memHs, inHs, outHs;
  logic [1:0]  unusedAddrBits;

  assign unusedAddrBits = addrWrData[1:0];

  assign memReq       = cmd.run && (dirQ ? fullQ : !haveQ);
  assign memWe        = dirQ;
  assign memWdata     = packQ;
  assign cardInReady  = cmd.run && dirQ && !fullQ;
  assign cardOutValid = cmd.run && !dirQ && haveQ;
  assign cardOutData  = packQ[8*byteIdx +: 8];

  assign memHs = memReq && memRdy;
  assign inHs  = cardInReady && cardInValid;
  assign outHs = cardOutValid && cardOutReady;

  // a word is finished once memory took it (inbound) or its last byte left (outbound)
  assign wordDone = dirQ ? memHs : (outHs && byteIdx == 2'd3);
  assign postAddr = dirQ ? addrQ + ADDR_W'(4) : addrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
    end else if (cmd.loadAddr) begin
      addrQ <= {addrWrData[ADDR_W-1:2], 2'b00};
    end else if (memHs) begin
      addrQ <= addrQ + ADDR_W'(4);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ    <= 1'b0;
      packQ   <= '0;
      byteIdx <= '0;
      fullQ   <= 1'b0;
      haveQ   <= 1'b0;
    end else if (cmd.clear) begin
      dirQ    <= cmd.dirIn;
      byteIdx <= '0;
      fullQ   <= 1'b0;
      haveQ   <= 1'b0;
    end else begin
      if (inHs) begin
        packQ[8*byteIdx +: 8] <= cardInData;
        byteIdx <= byteIdx + 2'd1;
        if (byteIdx == 2'd3) fullQ <= 1'b1;
      end
      if (memHs) begin
        if (dirQ) begin
          fullQ <= 1'b0;
        end else begin
          packQ   <= memRdata;
          haveQ   <= 1'b1;
          byteIdx <= '0;
        end
      end
      if (outHs) begin
        byteIdx <= byteIdx + 2'd1;
        if (byteIdx == 2'd3) haveQ <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sdma_ctrl.sv
module sdma_ctrl
  import sdma_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 16,
  parameter int LEN_W    = 12,
  parameter int CODE_W   = 3,
  parameter int BND_LOG2 = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [1:0]              dmaSel,
  input  logic [5:0]              xferMode,
  input  logic [LEN_W+CODE_W:0]   blkSizeReg,
  input  logic [CNT_W-1:0]        blkCntIn,
  input  logic                    startStb,
  input  logic                    sysAddrWrEn,
  input  logic [1:0]              stsEn,
  input  logic [1:0]              stsClr,
  input  logic                    wordDone,
  input  logic [ADDR_W-1:0]       postAddr,
  output dpCmd_t                  cmd,
  output logic                    busy,
  output logic [CNT_W-1:0]        blkCntOut,
  output logic [1:0]              stsQ
);

  localparam int WRD_W = LEN_W - 2;

  sdmaState_e          stQ, stD;
  logic [WRD_W-1:0]    wordsQ, lenQ, blkWords;
  logic [CNT_W-1:0]    blocksQ, cntQ;
  logic [CODE_W-1:0]   codeQ, bndCode;
  logic                cntEnQ;
  logic [ADDR_W-1:0]   bndMask;
  logic                startOk, lastWord, lastBlk, bndHit, setDone, setPause;
  logic [1:0]          setVec, stsD;
  logic                unusedBits;

  assign unusedBits = ^{xferMode[3:2], blkSizeReg[1:0], blkSizeReg[LEN_W+CODE_W]};

  assign blkWords = blkSizeReg[LEN_W-1:2];
  assign bndCode  = blkSizeReg[LEN_W +: CODE_W];

  // R2: SDMA only, DMA enabled, nonempty block, nonzero count when multi
  assign startOk = startStb && stQ == ST_IDLE && dmaSel == 2'b00 && xferMode[0]
                   && blkWords != '0 && (!xferMode[5] || blkCntIn != '0);

  assign bndMask  = (ADDR_W'(1) << (BND_LOG2 + int'(codeQ))) - ADDR_W'(1);
  assign bndHit   = (postAddr & bndMask) == '0;
  assign lastWord = wordsQ == WRD_W'(1);
  assign lastBlk  = blocksQ == CNT_W'(1);
  assign setDone  = stQ == ST_RUN && wordDone && lastWord && lastBlk;
  assign setPause = stQ == ST_RUN && wordDone && !(lastWord && lastBlk) && bndHit;

  assign cmd.clear    = startOk;
  assign cmd.run      = stQ == ST_RUN;
  assign cmd.loadAddr = sysAddrWrEn && stQ != ST_RUN;  // R8
  assign cmd.dirIn    = xferMode[4];
  assign busy         = stQ != ST_IDLE;
  assign blkCntOut    = cntQ;

  always_comb begin
    stD = stQ;
    unique case (stQ)
      ST_IDLE:  if (startOk) stD = ST_RUN;
      ST_RUN:   if (setDone) stD = ST_IDLE;
                else if (setPause) stD = ST_PAUSE;
      ST_PAUSE: if (sysAddrWrEn) stD = ST_RUN;
      default:  stD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ     <= ST_IDLE;
      wordsQ  <= '0;
      lenQ    <= '0;
      blocksQ <= '0;
      cntQ    <= '0;
      codeQ   <= '0;
      cntEnQ  <= 1'b0;
    end else begin
      stQ <= stD;
      if (startOk) begin
        wordsQ  <= blkWords;
        lenQ    <= blkWords;
        blocksQ <= xferMode[5] ? blkCntIn : CNT_W'(1);  // R5
        cntQ    <= blkCntIn;
        codeQ   <= bndCode;
        cntEnQ  <= xferMode[1];
      end else if (stQ == ST_RUN && wordDone) begin
        if (lastWord) begin
          wordsQ <= lenQ;
          if (!lastBlk) blocksQ <= blocksQ - CNT_W'(1);
          if (cntEnQ && cntQ != '0) cntQ <= cntQ - CNT_W'(1);  // R6
        end else begin
          wordsQ <= wordsQ - WRD_W'(1);
        end
      end
    end
  end

  // R10 / R11: gated set wins over write-one-to-clear
  assign setVec[STS_DONE] = setDone;
  assign setVec[STS_DMA]  = setPause;

  for (genvar i = 0; i < 2; i++) begin : g_sts
    assign stsD[i] = (setVec[i] && stsEn[i]) ? 1'b1 : (stsClr[i] ? 1'b0 : stsQ[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stsQ <= '0;
    else       stsQ <= stsD;
  end

endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
  import sdma_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 16,
  parameter int LEN_W    = 12,
  parameter int CODE_W   = 3,
  parameter int BND_LOG2 = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            dmaSel,
  input  logic [5:0]            xferMode,
  input  logic [LEN_W+CODE_W:0] blkSizeReg,
  input  logic [CNT_W-1:0]      blkCntIn,
  input  logic                  startStb,
  input  logic                  sysAddrWrEn,
  input  logic [ADDR_W-1:0]     sysAddrWrData,
  input  logic [1:0]            stsEn,
  input  logic [1:0]            stsClr,
  output logic [ADDR_W-1:0]     sysAddrOut,
  output logic [CNT_W-1:0]      blkCntOut,
  output logic                  busy,
  output logic                  stsXferDone,
  output logic                  stsDmaInt,
  output logic                  memReq,
  output logic                  memWe,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [31:0]           memWdata,
  input  logic                  memRdy,
  input  logic [31:0]           memRdata,
  input  logic                  cardInValid,
  input  logic [7:0]            cardInData,
  output logic                  cardInReady,
  output logic                  cardOutValid,
  output logic [7:0]            cardOutData,
  input  logic                  cardOutReady
);

  dpCmd_t            cmd;
  logic              wordDone;
  logic [ADDR_W-1:0] postAddr;
  logic [ADDR_W-1:0] addrQ;
  logic [1:0]        sts;

  sdma_ctrl #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W), .CODE_W(CODE_W), .BND_LOG2(BND_LOG2)
  ) ctrl_i (
    .clk, .rstN, .dmaSel, .xferMode, .blkSizeReg, .blkCntIn, .startStb, .sysAddrWrEn,
    .stsEn, .stsClr, .wordDone, .postAddr, .cmd, .busy, .blkCntOut, .stsQ(sts)
  );

  sdma_dpath #(.ADDR_W(ADDR_W)) dpath_i (
    .clk, .rstN, .cmd, .addrWrData(sysAddrWrData), .addrQ, .wordDone, .postAddr,
    .memReq, .memWe, .memWdata, .memRdy, .memRdata,
    .cardInValid, .cardInData, .cardInReady, .cardOutValid, .cardOutData, .cardOutReady
  );

  assign sysAddrOut  = addrQ;
  assign memAddr     = addrQ;
  assign stsXferDone = sts[STS_DONE];
  assign stsDmaInt   = sts[STS_DMA];

endmodule

// File: rtl/sdma_engine_chk.sv
module sdma_engine_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              memReq,
  input logic              memRdy,
  input logic              cardInReady,
  input logic              cardOutValid,
  input logic              stsXferDone,
  input logic              stsDmaInt,
  input logic [ADDR_W-1:0] sysAddrOut,
  input logic [CNT_W-1:0]  blkCntOut
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq && !cardInReady && !cardOutValid); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    busy && memReq && memRdy |=> sysAddrOut == $past(sysAddrOut) + ADDR_W'(4)); // R4

  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    sysAddrOut[1:0] == 2'b00); // R4

  AST_CNT_NO_RISE: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> blkCntOut <= $past(blkCntOut)); // R6

  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stsDmaInt) |-> busy && !memReq && !cardInReady && !cardOutValid); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stsXferDone) |-> !busy); // R9

endmodule

bind sdma_engine sdma_engine_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/sdma_engine_tb_top.sv
module sdma_engine_tb_top;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN;
  logic [1:0]  dmaSel;
  logic [5:0]  xferMode;
  logic [15:0] blkSizeReg;
  logic [15:0] blkCntIn;
  logic        startStb, sysAddrWrEn;
  logic [31:0] sysAddrWrData;
  logic [1:0]  stsEn, stsClr;
  logic [31:0] sysAddrOut, memAddr, memWdata, memRdata;
  logic [15:0] blkCntOut;
  logic        busy, stsXferDone, stsDmaInt, memReq, memWe, memRdy;
  logic        cardInValid, cardInReady, cardOutValid, cardOutReady;
  logic [7:0]  cardInData, cardOutData;

  sdma_engine dut_i (.*);

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] memPat(input logic [31:0] a);
    return {a[15:0] ^ 16'hC35A, a[15:0]};
  endfunction

  function automatic logic [7:0] inPat(input int n);
    return 8'(n * 7 + 3);
  endfunction

  // ---------------- behavioural reference ----------------
  int          mSt, mIdx, mWords, mBlocks, mLen, mCode, inByte;
  logic [31:0] mAddr, mBuf;
  logic [15:0] mCnt;
  bit          mDone, mDma, mFull, mHave, mDir, mCntEn;

  always @(posedge clk) begin : model
    bit run, hsIn, hsMem, hsOut, wd, lw, lb, hit, sDone, sPause, okStart;
    logic [31:0] post, mask;
    int words;
    if (!rstN) begin
      mSt = 0; mAddr = 0; mCnt = 0; mDone = 0; mDma = 0; mFull = 0; mHave = 0;
      mIdx = 0; mBuf = 0; inByte = 0; mDir = 0; mWords = 0; mBlocks = 0; mLen = 0;
      mCode = 0; mCntEn = 0;
    end else begin
      run   = (mSt == 1);
      hsIn  = run && mDir && !mFull && cardInValid;
      hsMem = run && (mDir ? mFull : !mHave) && memRdy;
      hsOut = run && !mDir && mHave && cardOutReady;
      wd    = mDir ? hsMem : (hsOut && mIdx == 3);
      post  = mDir ? mAddr + 4 : mAddr;
      mask  = (32'd4096 << mCode) - 1;
      hit   = (post & mask) == 0;
      lw    = (mWords == 1);
      lb    = (mBlocks == 1);
      sDone  = run && wd && lw && lb;
      sPause = run && wd && !(lw && lb) && hit;
      if (hsIn) begin
        mBuf[mIdx*8 +: 8] = cardInData;
        inByte++;
        if (mIdx == 3) mFull = 1;
        mIdx = (mIdx + 1) % 4;
      end
      if (hsMem) begin
        if (mDir) mFull = 0;
        else begin mBuf = memPat(mAddr); mHave = 1; mIdx = 0; end
        mAddr = mAddr + 4;
      end
      if (hsOut) begin
        if (mIdx == 3) mHave = 0;
        mIdx = (mIdx + 1) % 4;
      end
      if (run && wd) begin
        if (lw) begin
          mWords = mLen;
          if (!lb) mBlocks--;
          if (mCntEn && mCnt != 0) mCnt--;
        end else mWords--;
      end
      mDone = (sDone && stsEn[0]) ? 1'b1 : (stsClr[0] ? 1'b0 : mDone);
      mDma  = (sPause && stsEn[1]) ? 1'b1 : (stsClr[1] ? 1'b0 : mDma);
      if (sysAddrWrEn && mSt != 1) mAddr = {sysAddrWrData[31:2], 2'b00};
      words = int'(blkSizeReg[11:2]);
      okStart = startStb && dmaSel == 2'b00 && xferMode[0] && words != 0
                && (!xferMode[5] || blkCntIn != 0);
      case (mSt)
        0: if (okStart) begin
             mSt = 1; mWords = words; mLen = words;
             mBlocks = xferMode[5] ? int'(blkCntIn) : 1;
             mCnt = blkCntIn; mCode = int'(blkSizeReg[14:12]); mCntEn = xferMode[1];
             mDir = xferMode[4]; mFull = 0; mHave = 0; mIdx = 0;
           end
        1: if (sDone) mSt = 0; else if (sPause) mSt = 2;
        default: if (sysAddrWrEn) mSt = 1;
      endcase
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin : compare
    bit eReq;
    #3;
    eReq = (mSt == 1) && (mDir ? mFull : !mHave);
    chk("R9 busy", busy, mSt != 0);
    chk("R4 sysAddrOut", sysAddrOut, mAddr);
    chk("R6 blkCntOut", blkCntOut, mCnt);
    chk("R10 stsXferDone", stsXferDone, mDone);
    chk("R7 stsDmaInt", stsDmaInt, mDma);
    chk("R3 memReq", memReq, eReq);
    chk("R3 cardInReady", cardInReady, (mSt == 1) && mDir && !mFull);
    chk("R3 cardOutValid", cardOutValid, (mSt == 1) && !mDir && mHave);
    if (eReq) begin
      chk("R4 memAddr", memAddr, mAddr);
      chk("R3 memWe", memWe, mDir);
      if (mDir) chk("R3 memWdata", memWdata, mBuf);
    end
    if ((mSt == 1) && !mDir && mHave) chk("R3 cardOutData", cardOutData, mBuf[mIdx*8 +: 8]);
  end

  // ---------------- environment ----------------
  assign memRdata = memPat(memAddr);

  always @(negedge clk) begin
    memRdy       <= ($urandom_range(0, 3) != 0);
    cardInValid  <= ($urandom_range(0, 3) != 0);
    cardOutReady <= ($urandom_range(0, 3) != 0);
    cardInData   <= inPat(inByte);
  end

  task automatic writeAddr(input logic [31:0] a);
    @(negedge clk); sysAddrWrEn = 1; sysAddrWrData = a;
    @(negedge clk); sysAddrWrEn = 0;
  endtask

  task automatic clearSts(input logic [1:0] m);
    @(negedge clk); stsClr = m;
    @(negedge clk); stsClr = 2'b00;
  endtask

  task automatic startXfer(input bit dir, input bit multi, input bit cntEn, input logic [11:0] len,
                           input logic [2:0] code, input logic [15:0] cnt, input logic [31:0] a);
    blkSizeReg = {1'b0, code, len};
    xferMode   = {multi, dir, 2'b00, cntEn, 1'b1};
    blkCntIn   = cnt;
    writeAddr(a);
    @(negedge clk); startStb = 1;
    @(negedge clk); startStb = 0;
  endtask

  task automatic waitStop();
    int n = 0;
    while (busy && !stsDmaInt && n < 20000) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    rstN = 0; dmaSel = 2'b00; xferMode = '0; blkSizeReg = '0; blkCntIn = '0;
    startStb = 0; sysAddrWrEn = 0; sysAddrWrData = '0; stsEn = 2'b11; stsClr = 2'b00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 addr", sysAddrOut, 0);
    chk("R1 sts", {stsDmaInt, stsXferDone}, 0);
    chk("R1 memReq", memReq, 0);
    rstN = 1;
    @(negedge clk);

    // card to memory, single block with count 5: one block only
    startXfer(1, 0, 1, 12'd16, 3'd0, 16'd5, 32'h100);
    waitStop();
    chk("R4 end addr", sysAddrOut, 32'h110);
    chk("R5 single block count", blkCntOut, 16'd4);
    chk("R9 done", {busy, stsXferDone}, 2'b01);
    // R11 write-0 keeps, write-1 clears
    clearSts(2'b10);
    chk("R11 write-0 keeps", stsXferDone, 1);
    clearSts(2'b01);
    chk("R11 write-1 clears", stsXferDone, 0);

    // memory to card, 3 blocks of 8 bytes from 0xFF8: pause at 0x1000
    startXfer(0, 1, 1, 12'd8, 3'd0, 16'd3, 32'hFF8);
    waitStop();
    chk("R7 paused", {busy, stsDmaInt}, 2'b11);
    chk("R7 pause addr", sysAddrOut, 32'h1000);
    chk("R6 after one block", blkCntOut, 16'd2);
    repeat (10) @(negedge clk);
    chk("R8 holds while paused", sysAddrOut, 32'h1000);
    clearSts(2'b10);
    writeAddr(sysAddrOut);
    waitStop();
    chk("R8 resumed to end", sysAddrOut, 32'h1010);
    chk("R6 count zero", blkCntOut, 16'd0);
    chk("R9 done after resume", {busy, stsXferDone}, 2'b01);
    clearSts(2'b11);

    // last word lands on boundary: completes, no pause
    startXfer(1, 0, 1, 12'd16, 3'd0, 16'd1, 32'hFF0);
    waitStop();
    chk("R7 no pause on last word", {busy, stsDmaInt, stsXferDone}, 3'b001);
    chk("R7 last addr", sysAddrOut, 32'h1000);
    clearSts(2'b11);

    // code 1 (8 KiB): 4 KiB multiple passed without pause
    startXfer(1, 1, 1, 12'd8, 3'd1, 16'd2, 32'hFF8);
    waitStop();
    chk("R7 8KiB no pause at 4KiB", {busy, stsDmaInt, stsXferDone}, 3'b001);
    chk("R4 addr", sysAddrOut, 32'h1008);
    clearSts(2'b11);

    // code 1 from 0x1FF8: pause at 0x2000, resume relocated
    startXfer(0, 1, 1, 12'd8, 3'd1, 16'd2, 32'h1FF8);
    waitStop();
    chk("R7 8KiB pause", {busy, stsDmaInt}, 2'b11);
    chk("R7 8KiB addr", sysAddrOut, 32'h2000);
    clearSts(2'b10);
    writeAddr(32'h3001);
    waitStop();
    chk("R8 relocated end", sysAddrOut, 32'h3008);
    chk("R9 done", stsXferDone, 1);
    clearSts(2'b11);

    // non-SDMA codes and disabled DMA leave engine idle
    for (int s = 1; s < 4; s++) begin
      dmaSel = 2'(s);
      startXfer(1, 0, 1, 12'd8, 3'd0, 16'd1, 32'h400);
      repeat (3) @(negedge clk);
      chk("R2 non-SDMA ignored", {busy, sysAddrOut}, {1'b0, 32'h400});
    end
    dmaSel = 2'b00;
    blkSizeReg = {4'd0, 12'd8}; xferMode = 6'b010000; blkCntIn = 16'd1;
    @(negedge clk); startStb = 1; @(negedge clk); startStb = 0;
    chk("R2 DMA disabled ignored", busy, 0);
    startXfer(1, 1, 1, 12'd8, 3'd0, 16'd0, 32'h400);
    chk("R2 zero count ignored", busy, 0);

    // completion flag disabled
    stsEn = 2'b10;
    startXfer(0, 0, 1, 12'd8, 3'd0, 16'd1, 32'h500);
    waitStop();
    repeat (2) @(negedge clk);
    chk("R10 done gated", {busy, stsXferDone}, 2'b00);
    stsEn = 2'b11;

    // address write while running is ignored; count enable off
    startXfer(1, 1, 0, 12'd64, 3'd0, 16'd2, 32'h200);
    repeat (5) @(negedge clk);
    writeAddr(32'h8000);
    waitStop();
    chk("R8 run write ignored", sysAddrOut, 32'h280);
    chk("R6 count held", blkCntOut, 16'd2);
    chk("R5 two blocks", stsXferDone, 1);
    clearSts(2'b11);

    repeat (5) @(negedge clk);
    finishRun();
  end

endmodule